// File: doc/BRIEF.md
# Address-Masked Eight-Line GPIO Controller

This block is a general-purpose I/O controller for eight lines, reached through an APB-style slave port. Its data register is mirrored across a window of addresses. The address bits just above the word offset act as a per-line mask, so that one bus access can sample or change any subset of lines. Lines outside the mask are left alone, and no read-modify-write sequence is needed. A direction register chooses, line by line, whether the controller drives the pad.

Every pad input passes through a two-stage synchroniser before software can observe it. An output line is therefore read back through the same path, after the pad has fed it in again. The bus port never stalls: PREADY is tied high, so there is no back-pressure. Each transfer is one setup cycle followed by one access cycle. The slave never signals an error.

Top module: `gpio_am_top`

## Requirements
- R1: After reset, every line is an input (pin_oe = 0x00), the output latch is 0x00, and the direction register reads 0x00.
- R2: A data write is an access-phase write whose offset has bits [11:10] = 0 and bits [1:0] = 0. It loads the output latch only in the lines whose mask bit (offset bit 2+i for line i) is 1. The other lines keep their previous value, and a mask of zero changes nothing.
- R3: A data read at such an offset returns the synchronised pad value in every line whose mask bit is 1, and returns 0 in every other line.
- R4: A pad change becomes visible to reads after two rising clock edges. Read data is presented whenever select is high with write low, so it can also be observed in the setup cycle.
- R5: The direction register sits at offset 0x400. It is written with all eight bits, no mask applies, and it reads back its value. pin_oe bit i equals direction bit i, where 1 means output.
- R6: pin_out always shows the output latch, which can be written while a line is an input. A line set to output reads back its driven value through the synchroniser.
- R7: Reads from any other offset return 0, and writes to any other offset change neither the output latch nor the direction register. This includes data-window offsets with bits [1:0] nonzero.
- R8: pready is always 1 and pslverr is always 0.
- R9: A setup cycle without an access cycle (penable low) writes nothing.
- R10: Only pwdata[7:0] is used. Read data bits [31:8] are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the controller |
| pwdata | input | 32 | Write data, low byte used |
| prdata | output | 32 | Read data, low byte meaningful |
| pready | output | 1 | Transfer complete, always 1 |
| pslverr | output | 1 | Error response, always 0 |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Output latch to the pads |
| pin_oe | output | 8 | Per-line output enable |

## Verification
Masked writes are tried with a full mask, a low-nibble mask, a single-bit mask and an empty mask, on top of a known latch value. This tells a correct merge apart from a plain overwrite and from a dropped write. Masked reads use full, sparse and empty masks on a pad pattern that mixes ones and zeros, with some lines as outputs and the rest as external inputs. This separates masking errors from readback-path errors. The synchroniser depth is pinned down by sampling read data once in the setup cycle (old value) and once in the access cycle (new value). Aliased offsets, offsets with bits [1:0] nonzero, setup-only cycles and high data bits check that nothing outside the defined decode has an effect.

// File: rtl/gpio_am_pkg.sv
package gpio_am_pkg;
  // Line count is fixed: the mask field in the address is exactly this wide.
  localparam int unsigned LINES    = 8;
  localparam int unsigned MASK_LSB = 2;
  localparam int unsigned MASK_MSB = MASK_LSB + LINES - 1;

  typedef logic [LINES-1:0] line_vec_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpio_am_decode.sv
module gpio_am_decode
  import gpio_am_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] DIR_OFFSET = 12'h400
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output line_vec_t         mask
);
  localparam int unsigned HI_BITS = ADDR_W - MASK_MSB - 1;

  logic hi_zero;
  logic lo_zero;

  assign hi_zero = (addr[ADDR_W-1:MASK_MSB+1] == {HI_BITS{1'b0}});
  assign lo_zero = (addr[MASK_LSB-1:0] == {MASK_LSB{1'b0}});
  assign mask    = addr[MASK_MSB:MASK_LSB];

  always_comb begin
    if (hi_zero && lo_zero)       sel = SEL_DATA;
    else if (addr == DIR_OFFSET)  sel = SEL_DIR;
    else                          sel = SEL_NONE;
  end
endmodule

// File: rtl/gpio_am_sync.sv
module gpio_am_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/gpio_am_regs.sv
module gpio_am_regs
  import gpio_am_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  reg_sel_e  sel,
  input  line_vec_t mask,
  input  line_vec_t wbyte,
  output line_vec_t dir_q,
  output line_vec_t out_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_DATA: out_q <= (out_q & ~mask) | (wbyte & mask);
        SEL_DIR:  dir_q <= wbyte;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_am_top.sv
module gpio_am_top
  import gpio_am_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [7:0]        pin_in,
  output logic [7:0]        pin_out,
  output logic [7:0]        pin_oe
);
  localparam int unsigned PAD_W = DATA_W - LINES;

  reg_sel_e  sel;
  line_vec_t mask;
  line_vec_t dir_q;
  line_vec_t out_q;
  line_vec_t pin_sync;
  line_vec_t rd_byte;
  logic      wr_en;
  logic      unused_hi;

  assign unused_hi = ^pwdata[DATA_W-1:LINES];

  gpio_am_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (paddr),
    .sel  (sel),
    .mask (mask)
  );

  gpio_am_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (pclk),
    .rst_n (presetn),
    .d     (pin_in),
    .q     (pin_sync)
  );

  assign wr_en = psel && penable && pwrite;

  gpio_am_regs u_regs (
    .clk   (pclk),
    .rst_n (presetn),
    .wr_en (wr_en),
    .sel   (sel),
    .mask  (mask),
    .wbyte (pwdata[LINES-1:0]),
    .dir_q (dir_q),
    .out_q (out_q)
  );

  always_comb begin
    rd_byte = '0;
    if (psel && !pwrite) begin
      unique case (sel)
        SEL_DATA: rd_byte = pin_sync & mask;
        SEL_DIR:  rd_byte = dir_q;
        default:  rd_byte = '0;
      endcase
    end
  end

  assign prdata  = {{PAD_W{1'b0}}, rd_byte};
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_am_checker.sv
module gpio_am_checker (
  input logic        pclk,
  input logic        presetn,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic [7:0]  wdata_lo,
  input logic [31:0] prdata,
  input logic [7:0]  pin_out,
  input logic [7:0]  pin_oe
);
  logic       acc;
  logic       in_window;
  logic       is_dir;
  logic [7:0] amask;

  assign acc       = psel && penable;
  assign in_window = (paddr[11:10] == 2'b00) && (paddr[1:0] == 2'b00);
  assign is_dir    = (paddr == 12'h400);
  assign amask     = paddr[9:2];

  // R1: state just out of reset
  assert_reset_state_R1: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(presetn) |-> (pin_out == 8'h00 && pin_oe == 8'h00));

  // R2: masked merge of the output latch
  assert_masked_write_R2: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && pwrite && in_window) |=>
      ((pin_out & ~$past(amask)) == ($past(pin_out) & ~$past(amask))) &&
      ((pin_out & $past(amask)) == ($past(wdata_lo) & $past(amask))));

  // R3: unmasked lines read zero
  assert_masked_read_R3: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && !pwrite && in_window) |-> ((prdata[7:0] & ~amask) == 8'h00));

  // R5 / R7: direction only moves on a write at its offset
  assert_dir_stable_R5: assert property (@(posedge pclk) disable iff (!presetn)
    !(acc && pwrite && is_dir) |=> $stable(pin_oe));

  // R7 / R9: latch only moves on an access-phase data write
  assert_out_stable_R7: assert property (@(posedge pclk) disable iff (!presetn)
    !(acc && pwrite && in_window) |=> $stable(pin_out));

  // R7 / R10: undecoded reads return zero, upper bits always zero
  assert_undecoded_read_R7: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && !pwrite && !in_window && !is_dir) |-> (prdata == 32'h0));
endmodule

bind gpio_am_top gpio_am_checker u_chk (
  .pclk     (pclk),
  .presetn  (presetn),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .wdata_lo (pwdata[7:0]),
  .prdata   (prdata),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe)
);

// File: tb/tb_gpio_am_top.sv
`timescale 1ns/1ps
module tb_gpio_am_top;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  pin_in, pin_out, pin_oe;
  logic [7:0]  ext = 8'h00;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 pclk = ~pclk;  // 125 MHz

  // pad model: driven lines loop back, others follow the external source
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_am_top dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per access-phase read
  always @(negedge pclk) begin
    if (presetn && psel && penable && !pwrite) begin
      if (exp_q.size() == 0) chk("unexpected read", prdata, 32'hxxxxxxxx);
      else chk(tag_q.pop_front(), prdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(posedge pclk); #1 psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(posedge pclk); #1 penable = 1;
    @(posedge pclk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge pclk); #1 psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(posedge pclk); #1 penable = 1;
    @(posedge pclk); #1 psel = 0; penable = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge pclk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge pclk);
    #1 presetn = 1;
    // R1 / R8: reset state and bus responses
    chk("R1 pin_oe", {24'h0, pin_oe}, 32'h00);
    chk("R1 pin_out", {24'h0, pin_out}, 32'h00);
    chk("R8 pready", {31'h0, pready}, 32'h1);
    chk("R8 pslverr", {31'h0, pslverr}, 32'h0);
    rd(12'h400, 32'h0, "R1 dir read");
    rd(12'h3FC, 32'h0, "R1 data read");

    // R2: masked writes
    wr(12'h3FC, 32'h5A); chk("R2 full mask", {24'h0, pin_out}, 32'h5A);
    wr(12'h03C, 32'hFF); chk("R2 low nibble", {24'h0, pin_out}, 32'h5F);
    wr(12'h200, 32'h80); chk("R2 bit7 only", {24'h0, pin_out}, 32'hDF);
    wr(12'h000, 32'h00); chk("R2 empty mask", {24'h0, pin_out}, 32'hDF);
    chk("R6 latch while input", {24'h0, pin_oe}, 32'h00);

    // R3: masked reads, all lines inputs
    ext = 8'h3C; settle();
    rd(12'h3FC, 32'h3C, "R3 full mask");
    rd(12'h210, 32'h04, "R3 mask 0x84");
    rd(12'h000, 32'h00, "R3 empty mask");

    // R5 / R6: direction and loopback
    wr(12'h400, 32'hF0);
    chk("R5 pin_oe", {24'h0, pin_oe}, 32'hF0);
    rd(12'h400, 32'hF0, "R5 dir readback");
    settle();
    rd(12'h3FC, 32'hDC, "R6 loopback");
    rd(12'h300, 32'hC0, "R3 mask 0xC0");

    // R4: two-edge synchroniser latency
    @(posedge pclk); #1 ext = 8'h33;
    exp_q.push_back(32'h03); tag_q.push_back("R4 access new value");
    @(posedge pclk); #1 psel = 1; pwrite = 0; penable = 0; paddr = 12'h03C;
    #2 chk("R4 setup old value", prdata, 32'h0C);
    @(posedge pclk); #1 penable = 1;
    @(posedge pclk); #1 psel = 0; penable = 0;

    // R7: undecoded offsets
    wr(12'h401, 32'hFF); wr(12'h3FD, 32'h00); wr(12'h800, 32'h00); wr(12'h404, 32'h00);
    chk("R7 dir kept", {24'h0, pin_oe}, 32'hF0);
    chk("R7 latch kept", {24'h0, pin_out}, 32'hDF);
    rd(12'h404, 32'h0, "R7 read 0x404");
    rd(12'hC3C, 32'h0, "R7 read 0xC3C");
    rd(12'h402, 32'h0, "R7 read 0x402");

    // R9: setup cycle alone
    @(posedge pclk); #1 psel = 1; pwrite = 1; penable = 0; paddr = 12'h3FC; pwdata = 32'h0;
    @(posedge pclk); #1 psel = 0; pwrite = 0;
    @(posedge pclk); #1;
    chk("R9 no access no write", {24'h0, pin_out}, 32'hDF);

    // R10: upper data bits ignored
    wr(12'h3FC, 32'hFFFFFF00); chk("R10 data low byte", {24'h0, pin_out}, 32'h00);
    wr(12'h400, 32'hABCDEF12); chk("R10 dir low byte", {24'h0, pin_oe}, 32'h12);
    rd(12'h400, 32'h00000012, "R10 upper read zero");

    repeat (2) @(posedge pclk);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule